// File: doc/BRIEF.md
# Wrap-Around Carry Counter Bank

This block holds a bank of eight 32-bit counters that all advance on the same clock edge whenever a step is requested. On each step every counter adds a fixed per-lane constant and a single carry bit. The carry passes upward through the bank inside one iteration: lane 0 feeds lane 1, lane 1 feeds lane 2, and so on. The carry out of the top lane is kept in a register and feeds lane 0 on the next step, so the bank acts as one long counter whose top carry wraps around to the bottom.

The bank is seeded by a load strobe that writes all eight words and the stored carry at once. Outputs are the eight current words, packed with lane 0 in the least significant 32 bits, and the stored carry. A valid flag is high for exactly one cycle after each step. The whole carry chain is combinational, so one step takes a single clock cycle. The lane adder can be built as a full-width ripple add or as a split carry-select add, chosen by a parameter.

Top module: `wcb_counter_bank`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all eight counter words, the stored carry and the valid flag.
- R2: When load is high at a clock edge, ctr_out becomes load_value, carry_out becomes load_carry, and valid is low in the following cycle.
- R3: When load and step are both high at the same edge, the load wins: the outputs take the loaded values and valid stays low.
- R4: On a step, lane j's word, held at ctr_out[32*j +: 32], becomes its old value plus its constant plus its incoming carry, modulo 2^32. The default constants per lane are 0x4D34D34D for lanes 0, 3 and 6; 0xD34D34D3 for lanes 1, 4 and 7; and 0x34D34D34 for lanes 2 and 5.
- R5: The incoming carry of lane 0 on a step is the value carry_out held before that step.
- R6: The incoming carry of lane j, for j from 1 to 7, is the carry produced by lane j-1 in the same step, so one carry can ripple through all eight lanes in one edge.
- R7: A lane's carry is 1 exactly when old value plus constant plus incoming carry is at least 2^32. After a step, carry_out holds lane 7's carry.
- R8: With load and step both low, the counter words and carry_out keep their values.
- R9: valid is high during the single cycle after an edge that performed a step, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed strobe for all lanes and the stored carry |
| load_value | input | 256 | Seed words, lane 0 in bits 31:0 |
| load_carry | input | 1 | Seed value of the stored carry |
| step | input | 1 | Advance all lanes by one iteration |
| ctr_out | output | 256 | Current counter words, lane 0 in bits 31:0 |
| carry_out | output | 1 | Stored carry out of lane 7 |
| valid | output | 1 | One-cycle pulse after each step |

## Verification
Every result is registered once, so loaded words, stepped words, the stored carry and the valid pulse all show up one clock edge after the stimulus. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It then samples again one cycle later to confirm that valid has dropped and the words have held. Carry wrap and the full eight-lane ripple are checked with seed vectors that have known expected words, and a long run of steps is compared against a lane-by-lane model in the bench.

// File: rtl/wcb_pkg.sv
package wcb_pkg;

   localparam int unsigned DEF_LANES  = 8;
   localparam int unsigned DEF_WORD_W = 32;

   // Per-lane step constants, lane 0 in the least significant word.
   localparam logic [DEF_LANES*DEF_WORD_W-1:0] DEF_STEP_CONSTS = {
      32'hD34D34D3, 32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3,
      32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3, 32'h4D34D34D
   };

   typedef enum logic [1:0] {
      BANK_HOLD = 2'd0,
      BANK_STEP = 2'd1,
      BANK_LOAD = 2'd2,
      BANK_CLR  = 2'd3
   } bank_op_e;

endpackage

// File: rtl/wcb_lane_add.sv
module wcb_lane_add #(
   parameter int unsigned WORD_W    = 32,
   parameter bit          SPLIT_ADD = 1'b0
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic [WORD_W-1:0] step_k,
   input  logic              cin,
   output logic [WORD_W-1:0] word_out,
   output logic              cout
);

   generate
      if (SPLIT_ADD) begin : g_split
         localparam int unsigned LO_W = WORD_W / 2;
         localparam int unsigned HI_W = WORD_W - LO_W;

         logic [LO_W:0] lo_sum;
         logic [HI_W:0] hi_sum0;
         logic [HI_W:0] hi_sum1;
         logic [HI_W:0] hi_sel;

         always_comb begin
            lo_sum  = {1'b0, word_in[LO_W-1:0]} + {1'b0, step_k[LO_W-1:0]}
                      + {{LO_W{1'b0}}, cin};
            hi_sum0 = {1'b0, word_in[WORD_W-1:LO_W]} + {1'b0, step_k[WORD_W-1:LO_W]};
            hi_sum1 = {1'b0, word_in[WORD_W-1:LO_W]} + {1'b0, step_k[WORD_W-1:LO_W]}
                      + {{HI_W{1'b0}}, 1'b1};
            hi_sel   = lo_sum[LO_W] ? hi_sum1 : hi_sum0;
            word_out = {hi_sel[HI_W-1:0], lo_sum[LO_W-1:0]};
            cout     = hi_sel[HI_W];
         end
      end else begin : g_wide
         logic [WORD_W:0] full_sum;

         always_comb begin
            full_sum = {1'b0, word_in} + {1'b0, step_k} + {{WORD_W{1'b0}}, cin};
            word_out = full_sum[WORD_W-1:0];
            cout     = full_sum[WORD_W];
         end
      end
   endgenerate

endmodule

// File: rtl/wcb_carry_chain.sv
module wcb_carry_chain #(
   parameter int unsigned                    LANES       = 8,
   parameter int unsigned                    WORD_W      = 32,
   parameter bit                             SPLIT_ADD   = 1'b0,
   parameter logic [LANES*WORD_W-1:0]        STEP_CONSTS = '0
) (
   input  logic [LANES*WORD_W-1:0] cur_words,
   input  logic                    wrap_cin,
   output logic [LANES*WORD_W-1:0] nxt_words,
   output logic                    top_cout
);

   logic [LANES:0] chain_c;

   assign chain_c[0] = wrap_cin;

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         wcb_lane_add #(
            .WORD_W    (WORD_W),
            .SPLIT_ADD (SPLIT_ADD)
         ) lane_i (
            .word_in  (cur_words[j*WORD_W +: WORD_W]),
            .step_k   (STEP_CONSTS[j*WORD_W +: WORD_W]),
            .cin      (chain_c[j]),
            .word_out (nxt_words[j*WORD_W +: WORD_W]),
            .cout     (chain_c[j+1])
         );
      end
   endgenerate

   assign top_cout = chain_c[LANES];

endmodule

// File: rtl/wcb_state_regs.sv
module wcb_state_regs
   import wcb_pkg::*;
#(
   parameter int unsigned LANES  = 8,
   parameter int unsigned WORD_W = 32
) (
   input  logic                    clk,
   input  bank_op_e                op,
   input  logic [LANES*WORD_W-1:0] seed_words,
   input  logic                    seed_carry,
   input  logic [LANES*WORD_W-1:0] stepped_words,
   input  logic                    stepped_carry,
   output logic [LANES*WORD_W-1:0] words_q,
   output logic                    carry_q,
   output logic                    valid_q
);

   always_ff @(posedge clk) begin
      unique case (op)
         BANK_CLR: begin
            words_q <= '0;
            carry_q <= 1'b0;
            valid_q <= 1'b0;
         end
         BANK_LOAD: begin
            words_q <= seed_words;
            carry_q <= seed_carry;
            valid_q <= 1'b0;
         end
         BANK_STEP: begin
            words_q <= stepped_words;
            carry_q <= stepped_carry;
            valid_q <= 1'b1;
         end
         default: begin
            valid_q <= 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/wcb_counter_bank.sv
module wcb_counter_bank
   import wcb_pkg::*;
#(
   parameter int unsigned                 LANES       = DEF_LANES,
   parameter int unsigned                 WORD_W      = DEF_WORD_W,
   parameter bit                          SPLIT_ADD   = 1'b0,
   parameter logic [LANES*WORD_W-1:0]     STEP_CONSTS = DEF_STEP_CONSTS
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [LANES*WORD_W-1:0] load_value,
   input  logic                    load_carry,
   input  logic                    step,
   output logic [LANES*WORD_W-1:0] ctr_out,
   output logic                    carry_out,
   output logic                    valid
);

   localparam int unsigned BANK_W = LANES * WORD_W;

   generate
      if (LANES < 2) begin : g_bad_lanes
         $error("wcb_counter_bank: LANES must be at least 2");
      end
      if (WORD_W < 2) begin : g_bad_width
         $error("wcb_counter_bank: WORD_W must be at least 2");
      end
      if (SPLIT_ADD && (WORD_W % 2 != 0)) begin : g_bad_split
         $error("wcb_counter_bank: split adder needs an even WORD_W");
      end
   endgenerate

   bank_op_e          op;
   logic [BANK_W-1:0] stepped_words;
   logic              stepped_carry;

   always_comb begin
      if (rst)       op = BANK_CLR;
      else if (load) op = BANK_LOAD;
      else if (step) op = BANK_STEP;
      else           op = BANK_HOLD;
   end

   wcb_carry_chain #(
      .LANES       (LANES),
      .WORD_W      (WORD_W),
      .SPLIT_ADD   (SPLIT_ADD),
      .STEP_CONSTS (STEP_CONSTS)
   ) chain_i (
      .cur_words (ctr_out),
      .wrap_cin  (carry_out),
      .nxt_words (stepped_words),
      .top_cout  (stepped_carry)
   );

   wcb_state_regs #(
      .LANES  (LANES),
      .WORD_W (WORD_W)
   ) regs_i (
      .clk           (clk),
      .op            (op),
      .seed_words    (load_value),
      .seed_carry    (load_carry),
      .stepped_words (stepped_words),
      .stepped_carry (stepped_carry),
      .words_q       (ctr_out),
      .carry_q       (carry_out),
      .valid_q       (valid)
   );

endmodule

// File: rtl/wcb_checker.sv
module wcb_checker #(
   parameter int unsigned             LANES       = 8,
   parameter int unsigned             WORD_W      = 32,
   parameter logic [LANES*WORD_W-1:0] STEP_CONSTS = '0
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    load,
   input logic [LANES*WORD_W-1:0] load_value,
   input logic                    load_carry,
   input logic                    step,
   input logic [LANES*WORD_W-1:0] ctr_out,
   input logic                    carry_out,
   input logic                    valid
);

   localparam logic [WORD_W-1:0] K0 = STEP_CONSTS[0 +: WORD_W];
   localparam logic [WORD_W-1:0] K1 = STEP_CONSTS[WORD_W +: WORD_W];

   logic [WORD_W-1:0] prev_w0;
   logic [WORD_W-1:0] prev_w1;
   logic              prev_c;
   logic [WORD_W:0]   exp0;
   logic [WORD_W:0]   exp1;

   always_ff @(posedge clk) begin
      prev_w0 <= ctr_out[0 +: WORD_W];
      prev_w1 <= ctr_out[WORD_W +: WORD_W];
      prev_c  <= carry_out;
   end

   always_comb begin
      exp0 = {1'b0, prev_w0} + {1'b0, K0} + {{WORD_W{1'b0}}, prev_c};
      exp1 = {1'b0, prev_w1} + {1'b0, K1} + {{WORD_W{1'b0}}, exp0[WORD_W]};
   end

   assert_load_seed_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> (ctr_out == $past(load_value)) && (carry_out == $past(load_carry)) && !valid);

   assert_load_wins_R3: assert property (@(posedge clk) disable iff (rst)
      (load && step) |=> !valid);

   assert_lane0_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> ctr_out[0 +: WORD_W] == exp0[WORD_W-1:0]);

   assert_lane1_ripple_R6: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> ctr_out[WORD_W +: WORD_W] == exp1[WORD_W-1:0]);

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!step && !load) |=> $stable(ctr_out) && $stable(carry_out));

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      (step && !load) |=> valid);

   assert_valid_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !(step && !load) |=> !valid);

endmodule

bind wcb_counter_bank wcb_checker #(
   .LANES       (LANES),
   .WORD_W      (WORD_W),
   .STEP_CONSTS (STEP_CONSTS)
) chk_i (
   .clk        (clk),
   .rst        (rst),
   .load       (load),
   .load_value (load_value),
   .load_carry (load_carry),
   .step       (step),
   .ctr_out    (ctr_out),
   .carry_out  (carry_out),
   .valid      (valid)
);

// File: tb/wcb_counter_bank_tb.sv
module wcb_counter_bank_tb_top;

   localparam logic [255:0] KS = {
      32'hD34D34D3, 32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3,
      32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3, 32'h4D34D34D
   };
   localparam logic [255:0] NOT_KS = ~KS;

   typedef struct packed {
      logic [255:0] seed;
      logic         seed_c;
      logic [255:0] exp_w;
      logic         exp_c;
   } vec_t;

   // seed, seed carry, expected words after one step, expected carry
   localparam vec_t VECS [4] = '{
      '{256'h0,          1'b0, KS,           1'b0},
      '{{256{1'b1}},     1'b1, KS,           1'b1},
      '{NOT_KS,          1'b1, 256'h0,       1'b1},
      '{NOT_KS,          1'b0, {256{1'b1}},  1'b0}
   };

   logic         clk = 1'b0;
   logic         rst;
   logic         load;
   logic [255:0] load_value;
   logic         load_carry;
   logic         step;
   logic [255:0] ctr_out;
   logic         carry_out;
   logic         valid;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   wcb_counter_bank dut_i (
      .clk        (clk),
      .rst        (rst),
      .load       (load),
      .load_value (load_value),
      .load_carry (load_carry),
      .step       (step),
      .ctr_out    (ctr_out),
      .carry_out  (carry_out),
      .valid      (valid)
   );

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bench model of one step, built lane by lane from R4 to R7.
   function automatic logic [256:0] model_step(input logic [255:0] w, input logic c);
      logic [255:0] r;
      logic         cc;
      cc = c;
      for (int j = 0; j < 8; j++) begin
         logic [32:0] s;
         s = {1'b0, w[j*32 +: 32]} + {1'b0, KS[j*32 +: 32]} + {32'h0, cc};
         r[j*32 +: 32] = s[31:0];
         cc = s[32];
      end
      return {cc, r};
   endfunction

   task automatic do_load(input logic [255:0] v, input logic c);
      load = 1'b1; load_value = v; load_carry = c;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic do_step();
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%0d expected<=100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [256:0] m;
      rst = 1'b1; load = 1'b0; step = 1'b0; load_value = '0; load_carry = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset words", ctr_out, 256'h0);
      chk("R1 reset carry", {255'h0, carry_out}, 256'h0);
      chk("R1 reset valid", {255'h0, valid}, 256'h0);

      // Table of seeds with known results after one step.
      for (int i = 0; i < 4; i++) begin
         do_load(VECS[i].seed, VECS[i].seed_c);
         chk("R2 load words", ctr_out, VECS[i].seed);
         chk("R2 load carry", {255'h0, carry_out}, {255'h0, VECS[i].seed_c});
         chk("R2 load valid low", {255'h0, valid}, 256'h0);
         do_step();
         chk("R4 R6 stepped words", ctr_out, VECS[i].exp_w);
         chk("R5 R7 stored carry", {255'h0, carry_out}, {255'h0, VECS[i].exp_c});
         chk("R9 valid after step", {255'h0, valid}, 256'h1);
         @(negedge clk);
         chk("R9 valid drops", {255'h0, valid}, 256'h0);
         chk("R8 idle hold", ctr_out, VECS[i].exp_w);
      end

      // Load and step together: load wins.
      load = 1'b1; step = 1'b1; load_value = 256'h1234_5678; load_carry = 1'b1;
      @(negedge clk);
      load = 1'b0; step = 1'b0;
      chk("R3 load beats step words", ctr_out, 256'h1234_5678);
      chk("R3 load beats step valid", {255'h0, valid}, 256'h0);

      // Long run against the model, with idle gaps.
      do_load(256'h89AB_CDEF_0123_4567_FEDC_BA98_7654_3210_0F0F_F0F0_5A5A_A5A5_FFFF_0000_8000_7FFF, 1'b0);
      m = {1'b0, ctr_out};
      for (int n = 0; n < 40; n++) begin
         m = model_step(m[255:0], m[256]);
         do_step();
         chk("R4 run words", ctr_out, m[255:0]);
         chk("R7 run carry", {255'h0, carry_out}, {255'h0, m[256]});
         if (n % 5 == 0) begin
            @(negedge clk);
            chk("R8 gap hold", ctr_out, m[255:0]);
         end
      end

      // Back-to-back steps keep valid high.
      step = 1'b1;
      @(negedge clk);
      chk("R9 valid back to back 1", {255'h0, valid}, 256'h1);
      @(negedge clk);
      step = 1'b0;
      chk("R9 valid back to back 2", {255'h0, valid}, 256'h1);

      // Reset after activity clears everything.
      do_load({256{1'b1}}, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 late reset words", ctr_out, 256'h0);
      chk("R1 late reset carry", {255'h0, carry_out}, 256'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule